// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Snapshot Registers

This block keeps wall-clock time and date in packed BCD counters. It is driven by a 32.768 kHz enable pulse (`slowTick`) sampled in the fast system clock domain. A prescaler turns that pulse into a once-per-second advance. Seven counters hold seconds, minutes, hours (24-hour format only), day of month, month, a two-digit year standing for 2000 to 2099, and a weekday numbered 1 to 7 with 7 meaning Sunday.

A host reaches the counters and one control byte through a plain byte-wide port. The port has a write strobe and a combinational read path. To set the clock, software sets the halt bit, writes the seven counters, and clears the halt bit again.

For a coherent read, software first raises the snapshot bit. This copies all seven counters into shadow registers on a single edge. Software then sets the read-source bit so that reads come from that frozen copy and cannot straddle a rollover.

A build parameter selects a legacy calendar in which November runs to day 31.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, the control byte reads 0x00. The counters read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x06. The prescaler starts from zero, so the first second completes after exactly `TICKS_PER_SEC` slowTick pulses once the clock is released.
- R2: Addresses 0x00 to 0x06 map, in order, to seconds, minutes, hours, day, month, year and weekday. Each holds packed BCD (high nibble tens, low nibble units). Read data follows the address in the same cycle.
- R3: The control byte sits at address 0x10. While its bit 0 (halt) is 1, no counter advances whatever slowTick does, and the prescaler is held at zero.
- R4: While running, every `TICKS_PER_SEC`-th slowTick pulse advances seconds by one. Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the day.
- R5: A control write that takes bit 6 (snapshot) from 0 to 1 copies all seven counters into the shadow registers on that edge. Later counting does not change the copy.
- R6: With control bit 7 (read source) at 1, reads of 0x00 to 0x06 return the shadow copy; at 0 they return the live counters.
- R7: The day wraps to 01 after the last day of the month and the month advances. The last day is 28 for February, or 29 when the year value is divisible by 4. It is 30 for April, June, September and November, and 31 otherwise. Month 12 wraps to 01 and advances the year, which wraps from 99 to 00.
- R8: The weekday advances whenever the day advances and wraps from 7 to 1.
- R9: Writes to 0x00 to 0x06 load the counter only while halt is 1. While running, such writes are ignored and the counter keeps its value.
- R10: The whole control byte reads back as written; bits 1 to 5 have no effect. Reads of any address other than 0x00 to 0x06 and 0x10 return 0x00, and writes to them change nothing.
- R11: With `LEGACY_NOV31` = 1, November's last day is 31 instead of 30; all other months are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| busWrEn | input | 1 | Host write strobe for the addressed byte |
| busAddr | input | 8 | Host byte address for reads and writes |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Read data for the current address |

## Verification
The bench runs two instances, standard and legacy, from the same stimulus.

It drives irregular slowTick patterns so that a prescaler which counted clocks instead of pulses, or kept a remainder across a halt, lands on the wrong second. It loads times just before minute, hour, day, month and year boundaries, including February in leap and non-leap years and the end of the year with weekday 7. A wrong month-length table, a missed carry or a weekday that does not wrap from 7 to 1 therefore shows up as a wrong date.

The snapshot is taken mid-run and read back after further counting, which catches a copy that keeps tracking the live counters. A write during running catches counters that accept loads while they advance.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int FIELD_COUNT = 7;
  localparam logic [7:0] CTRL_ADDR = 8'h10;
  localparam int HALT_BIT = 0;
  localparam int SNAP_BIT = 6;
  localparam int SRC_BIT  = 7;

  // Strobes handed from the control unit to the datapath.
  typedef struct packed {
    logic                   secTick;   // one-second advance
    logic                   capture;   // copy live counters to shadow
    logic                   shadowSel; // reads come from shadow
    logic [FIELD_COUNT-1:0] fieldLoad; // host load, one per counter
  } rtcStrobe_t;

  // Increment a packed BCD byte; caller handles wrap limits.
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year (two BCD digits) divisible by 4.
  function automatic logic bcdLeap(input logic [7:0] yr);
    logic [3:0] ones;
    ones = yr[3:0];
    if (yr[4]) return (ones == 4'd2) || (ones == 4'd6);
    return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  endfunction

  // Last day of a month, BCD in and out.
  function automatic logic [7:0] lastDayOf(input logic [7:0] mon,
                                           input logic [7:0] yr,
                                           input logic legacyNov);
    case (mon)
      8'h02:               return bcdLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09: return 8'h30;
      8'h11:               return legacyNov ? 8'h31 : 8'h30;
      default:             return 8'h31;
    endcase
  endfunction

  // Counter values after reset: 2000-01-01 00:00:00, weekday 6.
  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      3, 4:    return 8'h01;
      6:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output rtcStrobe_t        strb,
  output logic [DATA_W-1:0] ctrlReg
);

  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0]       preCnt;
  logic [FIELD_COUNT-1:0] loadVec;
  logic                   ctrlWrite;
  logic                   running;
  logic                   preWrap;

  assign ctrlWrite = busWrEn && (busAddr == ADDR_W'(CTRL_ADDR));
  assign running   = !ctrlReg[HALT_BIT];
  assign preWrap   = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctrlReg <= '0;
    else if (ctrlWrite) ctrlReg <= busWrData;
  end

  // Prescaler counts slowTick pulses; held at zero while halted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         preCnt <= '0;
    else if (!running) preCnt <= '0;
    else if (slowTick) preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  // Host loads to the counters are honoured only while halted.
  for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_load
    assign loadVec[i] = busWrEn && !running && (busAddr == ADDR_W'(i));
  end

  always_comb begin
    strb.secTick   = running && slowTick && preWrap;
    strb.capture   = ctrlWrite && busWrData[SNAP_BIT] && !ctrlReg[SNAP_BIT];
    strb.shadowSel = ctrlReg[SRC_BIT];
    strb.fieldLoad = loadVec;
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter bit LEGACY_NOV31 = 1'b0,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] busRdData
);

  localparam int SEC = 0, MIN = 1, HOUR = 2, DAY = 3, MON = 4, YEAR = 5, WDAY = 6;

  logic [7:0]             live   [FIELD_COUNT];
  logic [7:0]             shadow [FIELD_COUNT];
  logic [7:0]             nextVal[FIELD_COUNT];
  logic [FIELD_COUNT-1:0] adv;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap, yearWrap;

  always_comb begin
    secWrap  = (live[SEC]  == 8'h59);
    minWrap  = (live[MIN]  == 8'h59);
    hourWrap = (live[HOUR] == 8'h23);
    dayWrap  = (live[DAY]  == lastDayOf(live[MON], live[YEAR], LEGACY_NOV31));
    monWrap  = (live[MON]  == 8'h12);
    yearWrap = (live[YEAR] == 8'h99);

    adv[SEC]  = strb.secTick;
    adv[MIN]  = adv[SEC]  && secWrap;
    adv[HOUR] = adv[MIN]  && minWrap;
    adv[DAY]  = adv[HOUR] && hourWrap;
    adv[MON]  = adv[DAY]  && dayWrap;
    adv[YEAR] = adv[MON]  && monWrap;
    adv[WDAY] = adv[DAY];

    nextVal[SEC]  = secWrap  ? 8'h00 : bcdInc(live[SEC]);
    nextVal[MIN]  = minWrap  ? 8'h00 : bcdInc(live[MIN]);
    nextVal[HOUR] = hourWrap ? 8'h00 : bcdInc(live[HOUR]);
    nextVal[DAY]  = dayWrap  ? 8'h01 : bcdInc(live[DAY]);
    nextVal[MON]  = monWrap  ? 8'h01 : bcdInc(live[MON]);
    nextVal[YEAR] = yearWrap ? 8'h00 : bcdInc(live[YEAR]);
    nextVal[WDAY] = (live[WDAY] == 8'h07) ? 8'h01 : live[WDAY] + 8'h01;
  end

  for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  live[i] <= resetValue(i);
      else if (strb.fieldLoad[i]) live[i] <= busWrData[7:0];
      else if (adv[i])            live[i] <= nextVal[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             shadow[i] <= resetValue(i);
      else if (strb.capture) shadow[i] <= live[i];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr < ADDR_W'(FIELD_COUNT))
      busRdData = DATA_W'(strb.shadowSel ? shadow[busAddr[2:0]] : live[busAddr[2:0]]);
    else if (busAddr == ADDR_W'(CTRL_ADDR))
      busRdData = ctrlReg;
  end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter bit LEGACY_NOV31  = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic       busWrEn,
  input  logic [7:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData
);

  rtcStrobe_t strb;
  logic [7:0] ctrlReg;

  rtc_cal_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .ADDR_W(8), .DATA_W(8)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .strb(strb), .ctrlReg(ctrlReg)
  );

  rtc_cal_datapath #(
    .LEGACY_NOV31(LEGACY_NOV31), .ADDR_W(8), .DATA_W(8)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWrData(busWrData), .ctrlReg(ctrlReg), .busRdData(busRdData)
  );

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
  import rtc_cal_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       slowTick,
  input logic       busWrEn,
  input logic [7:0] busAddr,
  input logic [7:0] busWrData,
  input logic [7:0] busRdData,
  input rtcStrobe_t strb
);

  // R3: a write that sets halt suppresses the next second advance
  p_halt_blocks_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == CTRL_ADDR && busWrData[HALT_BIT] |=> !strb.secTick);

  // R4: a second advance only happens on a slowTick pulse
  p_tick_needs_slow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.secTick |-> slowTick);

  // R5: the snapshot is a single-edge event
  p_capture_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);

  // R9: host loads never coincide with counting and hit one counter
  p_load_when_halted_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.fieldLoad != '0 |-> !strb.secTick && $onehot0(strb.fieldLoad));

  // R10: unmapped addresses read as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr > 8'h06 && busAddr != CTRL_ADDR) |-> busRdData == 8'h00);

  // R10: control byte reads back what was written
  p_ctrl_readback_r10: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == CTRL_ADDR |=>
      (busAddr != CTRL_ADDR || busRdData == $past(busWrData)));

endmodule

bind rtc_bcd_calendar rtc_cal_checker u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWrEn(busWrEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .strb(strb)
);

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;

  localparam int TPS = 4;
  localparam logic [7:0] CTRL = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] rdStd, rdLeg;

  always #2 clk = ~clk;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TPS), .LEGACY_NOV31(1'b0)) i_rtc_bcd_calendar (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(rdStd));

  rtc_bcd_calendar #(.TICKS_PER_SEC(TPS), .LEGACY_NOV31(1'b1)) i_rtc_bcd_calendar_legacy (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(rdLeg));

  int checks = 0;
  int fails = 0;
  int m[2][7]; // model: sec, min, hour, day, month, year, weekday

  function automatic int toBcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int daysIn(input int mon, input int yr, input bit leg);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 11) return leg ? 31 : 30;
    if (mon == 4 || mon == 6 || mon == 9) return 30;
    return 31;
  endfunction

  task automatic modelSecond(input int k);
    m[k][0]++;
    if (m[k][0] == 60) begin
      m[k][0] = 0; m[k][1]++;
      if (m[k][1] == 60) begin
        m[k][1] = 0; m[k][2]++;
        if (m[k][2] == 24) begin
          m[k][2] = 0; m[k][3]++;
          m[k][6] = (m[k][6] == 7) ? 1 : m[k][6] + 1;
          if (m[k][3] > daysIn(m[k][4], m[k][5], k == 1)) begin
            m[k][3] = 1; m[k][4]++;
            if (m[k][4] > 12) begin
              m[k][4] = 1; m[k][5] = (m[k][5] + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic advanceBoth(input int secs);
    for (int s = 0; s < secs; s++) begin
      modelSecond(0);
      modelSecond(1);
    end
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, input bit leg, output int got);
    busAddr = a;
    #1;
    got = leg ? int'(rdLeg) : int'(rdStd);
  endtask

  task automatic checkTime(input string req, input bit useStd, input bit useLeg);
    int got;
    for (int k = 0; k < 2; k++) begin
      if ((k == 0 && useStd) || (k == 1 && useLeg)) begin
        for (int f = 0; f < 7; f++) begin
          readReg(8'(f), k == 1, got);
          check(req, $sformatf("inst%0d field%0d", k, f), got, toBcd(m[k][f]));
        end
      end
    end
  endtask

  task automatic loadTime(input int s, input int mi, input int h, input int d,
                          input int mo, input int y, input int w);
    m[0] = '{s, mi, h, d, mo, y, w};
    m[1] = m[0];
    writeReg(CTRL, 8'h01);
    for (int f = 0; f < 7; f++) writeReg(8'(f), 8'(toBcd(m[0][f])));
  endtask

  task automatic runFor(input int n, input bit randTick);
    int cnt = 0;
    slowTick = 1'b0;
    writeReg(CTRL, 8'h00);
    for (int i = 0; i < n; i++) begin
      slowTick = randTick ? 1'($urandom_range(0, 1)) : 1'b1;
      @(posedge clk);
      if (slowTick) cnt++;
      #1;
    end
    slowTick = 1'b0;
    writeReg(CTRL, 8'h01);
    advanceBoth(cnt / TPS);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int got;
    int cnt;
    void'($urandom(20240));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset values and control byte
    m[0] = '{0, 0, 0, 1, 1, 0, 6};
    m[1] = m[0];
    checkTime("R1", 1, 1);
    readReg(CTRL, 0, got);
    check("R1", "ctrl after reset", got, 8'h00);

    // R1/R4: prescaler starts at zero, 3 pulses no second, the 4th makes one
    runFor(3, 0);
    checkTime("R1", 1, 0);
    runFor(TPS, 0);
    checkTime("R4", 1, 0);

    // R3: halted clock ignores slowTick
    loadTime(58, 59, 23, 31, 12, 99, 7);
    slowTick = 1'b1;
    repeat (20) @(posedge clk);
    #1 slowTick = 1'b0;
    checkTime("R3", 1, 1);

    // R2/R7/R8: full year rollover with weekday 7 -> 1
    runFor(2 * TPS, 0);
    checkTime("R7", 1, 1);
    readReg(8'h06, 0, got);
    check("R8", "weekday wrap", got, 8'h01);
    readReg(8'h05, 0, got);
    check("R7", "year wrap 99->00", got, 8'h00);

    // R7: February in leap and non-leap years, 30-day month
    loadTime(59, 59, 23, 28, 2, 24, 3);
    runFor(TPS, 0);
    checkTime("R7", 1, 1);
    loadTime(59, 59, 23, 28, 2, 23, 3);
    runFor(TPS, 0);
    checkTime("R7", 1, 1);
    loadTime(59, 59, 23, 29, 2, 0, 2);
    runFor(TPS, 0);
    checkTime("R7", 1, 1);
    loadTime(59, 59, 23, 30, 4, 15, 5);
    runFor(TPS, 0);
    checkTime("R7", 1, 1);

    // R11: November end in both instances
    loadTime(59, 59, 23, 30, 11, 21, 4);
    runFor(TPS, 0);
    readReg(8'h03, 0, got);
    check("R7", "std Nov30 -> day", got, 8'h01);
    readReg(8'h03, 1, got);
    check("R11", "legacy Nov30 -> day", got, 8'h31);
    readReg(8'h04, 1, got);
    check("R11", "legacy stays Nov", got, 8'h11);
    loadTime(59, 59, 23, 31, 11, 21, 4);
    m[1][3] = 31;
    runFor(TPS, 0);
    checkTime("R11", 0, 1);

    // R9: write while running is ignored; while halted it loads
    loadTime(10, 20, 5, 6, 7, 8, 1);
    slowTick = 1'b0;
    writeReg(CTRL, 8'h00);
    writeReg(8'h00, 8'h33);
    writeReg(8'h02, 8'h11);
    writeReg(CTRL, 8'h01);
    checkTime("R9", 1, 1);
    writeReg(8'h01, 8'h45);
    m[0][1] = 45; m[1][1] = 45;
    checkTime("R9", 1, 1);

    // R10: control readback, unmapped space
    writeReg(CTRL, 8'h3F);
    readReg(CTRL, 0, got);
    check("R10", "ctrl readback", got, 8'h3F);
    writeReg(CTRL, 8'h01);
    writeReg(8'h08, 8'hAA);
    readReg(8'h08, 0, got);
    check("R10", "unmapped 0x08", got, 8'h00);
    readReg(8'h07, 0, got);
    check("R10", "unmapped 0x07", got, 8'h00);
    readReg(8'h20, 1, got);
    check("R10", "unmapped 0x20", got, 8'h00);
    checkTime("R10", 1, 1);

    // R5/R6: snapshot while halted, then reload live
    loadTime(50, 34, 12, 15, 6, 42, 2);
    writeReg(CTRL, 8'h41);
    writeReg(CTRL, 8'h01);
    writeReg(8'h00, 8'h05);
    writeReg(CTRL, 8'h81);
    readReg(8'h00, 0, got);
    check("R6", "shadow seconds", got, 8'h50);
    readReg(8'h01, 1, got);
    check("R6", "shadow minutes", got, 8'h34);
    writeReg(CTRL, 8'h01);
    readReg(8'h00, 0, got);
    check("R6", "live seconds", got, 8'h05);

    // R5: snapshot while running stays frozen as counting continues
    writeReg(CTRL, 8'h00);
    cnt = 0;
    for (int i = 0; i < 9; i++) begin
      slowTick = 1'b1; @(posedge clk); cnt++; #1;
    end
    slowTick = 1'b0;
    writeReg(CTRL, 8'hC0);
    for (int i = 0; i < 8; i++) begin
      slowTick = 1'b1; @(posedge clk); cnt++; #1;
    end
    slowTick = 1'b0;
    writeReg(CTRL, 8'h81);
    readReg(8'h00, 0, got);
    check("R5", "snapshot seconds", got, toBcd(5 + 9 / TPS));
    readReg(8'h03, 1, got);
    check("R5", "snapshot day", got, 8'h15);
    writeReg(CTRL, 8'h01);
    readReg(8'h00, 0, got);
    check("R6", "live after snapshot", got, toBcd(5 + cnt / TPS));

    // R4/R7/R8: random times near boundaries, irregular slowTick
    for (int it = 0; it < 30; it++) begin
      int mo, yr, d;
      mo = $urandom_range(1, 12);
      yr = $urandom_range(0, 99);
      d  = ($urandom_range(0, 1) == 1) ? daysIn(mo, yr, 0) : $urandom_range(1, daysIn(mo, yr, 0));
      loadTime($urandom_range(50, 59),
               ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59),
               ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23),
               d, mo, yr, $urandom_range(1, 7));
      runFor($urandom_range(8, 60), 1);
      checkTime("R4", 1, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule